// File: doc/BRIEF.md
# Adaptive Gain Line-Rate Loop Controller

This block steers a line-locked clock synthesizer. It is fed one measurement per video line: a signed phase error between the incoming horizontal sync and the regenerated one, and a bit that says whether the incoming sync arrived early or late. From the history of those errors it picks one of five gain states. With the chosen gain it emits a phase correction for the current line and updates a saturating frequency word that sets the synthesizer's base rate.

The five states are normal (phase gain 1/32), slow (4x), medium (8x), fast (16x for both phase and frequency) and phase-only (16x for phase, nothing to the frequency word). The phase-only state absorbs a tape head-switch step without moving the loop frequency. Runs of large errors with a steady sign throw the loop straight into phase-only. Modest steady errors nudge it from normal up through slow to medium. Quiet lines bring it back down one state per run. A state change never clears the frequency word or any output, so the synthesized clock has no jump. A step detector for tape sources, which can be switched off, forces the 16x phase gain on any line whose error is above a step limit.

Top module: `gain_pll_ctrl`

## Requirements
- R1: While reset is held, and in the first cycles after it, `gain_state` is 1 (normal), `phase_adj` is 0, `freq_word` is 0 and `late_flag` is 0.
- R2: Outputs change only on the clock edge where `line_valid` is 1, and are visible from that edge on. In every other cycle all four outputs hold, whatever the other inputs do.
- R3: `phase_adj` for a line is `phase_err` arithmetically shifted right by 5, 3, 2, 1 or 1 bits, for state 1, 2, 3, 4 or 5. The state used is the one in force before that line's edge.
- R4: In states 1 to 4, `freq_word` gains `phase_err` shifted right by (phase shift + FREQ_EXTRA), default FREQ_EXTRA = 4. In state 5 the frequency word is unchanged.
- R5: `freq_word` is a signed FREQ_W-bit word that saturates at its most positive and most negative values and never wraps.
- R6: RUN_LEN (default 4) consecutive lines whose error has the same sign and magnitude above BIG_LIM (default 256) put the controller into state 5 from any state.
- R7: RUN_LEN consecutive lines whose error has the same sign and magnitude above SMALL_LIM (default 32) move state 1 to state 2 and state 2 to state 3. States 3, 4 and 5 are left as they are by such a run.
- R8: RUN_LEN consecutive lines with magnitude at or below SMALL_LIM lower the state by exactly one (state 5 to 4, 4 to 3, 3 to 2, 2 to 1). Every state change clears all run counts, so each further step needs a fresh run.
- R9: A line whose error sign differs from the previous line's restarts a signed run at length one. Alternating signs never count as a steady run.
- R10: With `vcr_det_en` at 1, a line whose error magnitude is above STEP_LIM (default 512) uses a phase shift of 1 for `phase_adj`. With `vcr_det_en` at 0 the input has no effect on the outputs.
- R11: `late_flag` is the line's `err_late` bit, held until the next line. A 0 means the input sync leads (speed up) and a 1 means it lags (slow down).
- R12: `gain_state` only takes the values 1 to 5. A drop in state is always by exactly one, and a rise is by exactly one or straight to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| line_valid | input | 1 | One-cycle strobe marking the cycle where this line's measurement is valid |
| phase_err | input | ERR_W | Signed sync phase error for the line |
| err_late | input | 1 | Early/late bit for the line: 0 input leads, 1 input lags |
| vcr_det_en | input | 1 | Enables the head-switch step boost of phase gain |
| gain_state | output | 3 | Current gain state, 1 to 5 |
| phase_adj | output | ERR_W | Signed phase correction for the line just taken |
| freq_word | output | FREQ_W | Signed saturating frequency word |
| late_flag | output | 1 | Early/late flag of the last line taken |

## Verification
Every output is registered, so the result of a line strobe shows up at the clock edge that samples the strobe. The bench drives each strobe for one cycle from a falling edge and reads the results at the next falling edge. The state change caused by the fourth line of a run is visible at that same edge. That line's own correction still uses the older state, so each expected value is worked out with the state in force before the line. After reset is released the bench waits three cycles for the synchronizer before the first strobe. For the hold requirement it reads the outputs several idle cycles after changing every other input.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic [2:0] {
    GS_NORM  = 3'd1,
    GS_SLOW  = 3'd2,
    GS_MED   = 3'd3,
    GS_FAST  = 3'd4,
    GS_PHASE = 3'd5
  } gain_st_t;

  // phase gain as a right shift amount for each state
  function automatic logic [3:0] gain_shift(gain_st_t st);
    case (st)
      GS_NORM: gain_shift = 4'd5;
      GS_SLOW: gain_shift = 4'd3;
      GS_MED:  gain_shift = 4'd2;
      default: gain_shift = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/gpc_run_ctr.sv
// Counts consecutive qualifying lines; optionally requires a steady sign.
module gpc_run_ctr #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_valid,
  input  logic clear,
  input  logic qual,
  input  logic neg,
  output logic hit
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_upd, cnt_d;
  logic          sign_q, sign_d;
  logic          cont;

  always_comb begin
    cont = qual && ((cnt_q == '0) || (neg == sign_q));
    if (cont) begin
      cnt_upd = (cnt_q == CW'(RUN_LEN)) ? cnt_q : cnt_q + 1'b1;
    end else if (qual) begin
      cnt_upd = CW'(1);
    end else begin
      cnt_upd = '0;
    end
    hit = line_valid && (cnt_upd == CW'(RUN_LEN));
    if (line_valid) begin
      cnt_d  = clear ? '0 : cnt_upd;
      sign_d = neg;
    end else begin
      cnt_d  = cnt_q;
      sign_d = sign_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sign_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sign_q <= sign_d;
    end
  end

endmodule

// File: rtl/gpc_history.sv
// Error magnitude classification and the three run trackers.
module gpc_history #(
  parameter int ERR_W     = 12,
  parameter int RUN_LEN   = 4,
  parameter int BIG_LIM   = 256,
  parameter int SMALL_LIM = 32,
  parameter int STEP_LIM  = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    line_valid,
  input  logic                    clear,
  input  logic signed [ERR_W-1:0] phase_err,
  output logic                    big_hit,
  output logic                    small_hit,
  output logic                    quiet_hit,
  output logic                    step_seen
);
  localparam int NRUN = 3;  // 0: large, 1: modest, 2: quiet

  logic signed [ERR_W:0] e_ext;
  logic        [ERR_W:0] mag;
  logic                  is_neg;
  logic [NRUN-1:0]       qual, negv, hits;

  always_comb begin
    e_ext  = {phase_err[ERR_W-1], phase_err};
    is_neg = phase_err[ERR_W-1];
    mag    = is_neg ? unsigned'(-e_ext) : unsigned'(e_ext);
    qual[0] = mag >  (ERR_W+1)'(BIG_LIM);
    qual[1] = mag >  (ERR_W+1)'(SMALL_LIM);
    qual[2] = mag <= (ERR_W+1)'(SMALL_LIM);
    negv[0] = is_neg;
    negv[1] = is_neg;
    negv[2] = 1'b0;  // quiet run ignores sign
    step_seen = mag > (ERR_W+1)'(STEP_LIM);
  end

  for (genvar i = 0; i < NRUN; i++) begin : g_run
    gpc_run_ctr #(.RUN_LEN(RUN_LEN)) u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_valid (line_valid),
      .clear      (clear),
      .qual       (qual[i]),
      .neg        (negv[i]),
      .hit        (hits[i])
    );
  end

  assign big_hit   = hits[0];
  assign small_hit = hits[1];
  assign quiet_hit = hits[2];

endmodule

// File: rtl/gpc_mode_fsm.sv
// Gain state selection from run results.
module gpc_mode_fsm
  import gpc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     line_valid,
  input  logic     big_hit,
  input  logic     small_hit,
  input  logic     quiet_hit,
  output gain_st_t state_q,
  output logic     clear
);
  gain_st_t state_d;

  always_comb begin
    state_d = state_q;
    if (line_valid) begin
      if (big_hit) begin
        state_d = GS_PHASE;
      end else if (small_hit && (state_q == GS_NORM)) begin
        state_d = GS_SLOW;
      end else if (small_hit && (state_q == GS_SLOW)) begin
        state_d = GS_MED;
      end else if (quiet_hit && (state_q != GS_NORM)) begin
        state_d = gain_st_t'(state_q - 3'd1);
      end
    end
    clear = line_valid && (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_NORM;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/gpc_gain_path.sv
// Phase correction and saturating frequency integrator.
module gpc_gain_path
  import gpc_pkg::*;
#(
  parameter int ERR_W      = 12,
  parameter int FREQ_W     = 16,
  parameter int FREQ_EXTRA = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_valid,
  input  gain_st_t                 state,
  input  logic                     boost,
  input  logic signed [ERR_W-1:0]  phase_err,
  input  logic                     err_late,
  output logic signed [ERR_W-1:0]  phase_adj,
  output logic signed [FREQ_W-1:0] freq_word,
  output logic                     late_flag
);
  localparam int SUM_W = ((ERR_W > FREQ_W) ? ERR_W : FREQ_W) + 1;
  localparam logic signed [SUM_W-1:0] FMAX = SUM_W'((2 ** (FREQ_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] FMIN = -FMAX - 1;

  logic        [3:0]        sh_ph;
  logic        [4:0]        sh_fq;
  logic signed [ERR_W-1:0]  adj_d, inc;
  logic signed [SUM_W-1:0]  sum;
  logic signed [FREQ_W-1:0] freq_d;
  logic signed [ERR_W-1:0]  adj_q;
  logic signed [FREQ_W-1:0] freq_q;
  logic                     late_q;

  always_comb begin
    sh_ph = boost ? 4'd1 : gain_shift(state);
    sh_fq = {1'b0, gain_shift(state)} + 5'(FREQ_EXTRA);
    adj_d = phase_err >>> sh_ph;
    if (state == GS_PHASE) begin
      inc = '0;
    end else begin
      inc = phase_err >>> sh_fq;
    end
    sum = $signed({{(SUM_W-FREQ_W){freq_q[FREQ_W-1]}}, freq_q})
        + $signed({{(SUM_W-ERR_W){inc[ERR_W-1]}}, inc});
    if (sum > FMAX) begin
      freq_d = FMAX[FREQ_W-1:0];
    end else if (sum < FMIN) begin
      freq_d = FMIN[FREQ_W-1:0];
    end else begin
      freq_d = sum[FREQ_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q  <= '0;
      freq_q <= '0;
      late_q <= 1'b0;
    end else if (line_valid) begin
      adj_q  <= adj_d;
      freq_q <= freq_d;
      late_q <= err_late;
    end
  end

  assign phase_adj = adj_q;
  assign freq_word = freq_q;
  assign late_flag = late_q;

endmodule

// File: rtl/gain_pll_ctrl.sv
module gain_pll_ctrl
  import gpc_pkg::*;
#(
  parameter int ERR_W      = 12,
  parameter int FREQ_W     = 16,
  parameter int RUN_LEN    = 4,
  parameter int BIG_LIM    = 256,
  parameter int SMALL_LIM  = 32,
  parameter int STEP_LIM   = 512,
  parameter int FREQ_EXTRA = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_valid,
  input  logic signed [ERR_W-1:0]  phase_err,
  input  logic                     err_late,
  input  logic                     vcr_det_en,
  output logic [2:0]               gain_state,
  output logic signed [ERR_W-1:0]  phase_adj,
  output logic signed [FREQ_W-1:0] freq_word,
  output logic                     late_flag
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic       big_hit, small_hit, quiet_hit, step_seen, clear;
  gain_st_t   state;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[1];

  gpc_history #(
    .ERR_W(ERR_W), .RUN_LEN(RUN_LEN), .BIG_LIM(BIG_LIM),
    .SMALL_LIM(SMALL_LIM), .STEP_LIM(STEP_LIM)
  ) u_hist (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .line_valid (line_valid),
    .clear      (clear),
    .phase_err  (phase_err),
    .big_hit    (big_hit),
    .small_hit  (small_hit),
    .quiet_hit  (quiet_hit),
    .step_seen  (step_seen)
  );

  gpc_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .line_valid (line_valid),
    .big_hit    (big_hit),
    .small_hit  (small_hit),
    .quiet_hit  (quiet_hit),
    .state_q    (state),
    .clear      (clear)
  );

  gpc_gain_path #(
    .ERR_W(ERR_W), .FREQ_W(FREQ_W), .FREQ_EXTRA(FREQ_EXTRA)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .line_valid (line_valid),
    .state      (state),
    .boost      (vcr_det_en && step_seen),
    .phase_err  (phase_err),
    .err_late   (err_late),
    .phase_adj  (phase_adj),
    .freq_word  (freq_word),
    .late_flag  (late_flag)
  );

  assign gain_state = state;

endmodule

// File: rtl/gpc_checker.sv
module gpc_checker #(
  parameter int ERR_W  = 12,
  parameter int FREQ_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     line_valid,
  input logic signed [ERR_W-1:0]  phase_err,
  input logic                     err_late,
  input logic                     vcr_det_en,
  input logic [2:0]               gain_state,
  input logic signed [ERR_W-1:0]  phase_adj,
  input logic signed [FREQ_W-1:0] freq_word,
  input logic                     late_flag
);
  localparam logic signed [FREQ_W-1:0] FTOP = {1'b0, {(FREQ_W-1){1'b1}}};
  localparam logic signed [FREQ_W-1:0] FBOT = {1'b1, {(FREQ_W-1){1'b0}}};

  a_r2_hold_between_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |=> ($stable(gain_state) && $stable(phase_adj)
                     && $stable(freq_word) && $stable(late_flag)));

  a_r3_normal_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && gain_state == 3'd1 && !vcr_det_en)
      |=> phase_adj == ($past(phase_err) >>> 5));

  a_r4_phase_state_freezes_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && gain_state == 3'd5) |=> $stable(freq_word));

  a_r5_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && freq_word == FTOP && !phase_err[ERR_W-1]) |=> freq_word == FTOP);

  a_r5_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && freq_word == FBOT && phase_err[ERR_W-1]) |=> freq_word == FBOT);

  a_r11_flag_follows_line: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> late_flag == $past(err_late));

  a_r12_state_range: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_state >= 3'd1) && (gain_state <= 3'd5));

  a_r8_single_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_state < $past(gain_state)) |-> gain_state == $past(gain_state) - 3'd1);

  a_r12_rise_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_state > $past(gain_state))
      |-> (gain_state == $past(gain_state) + 3'd1 || gain_state == 3'd5));

endmodule

bind gain_pll_ctrl gpc_checker #(.ERR_W(ERR_W), .FREQ_W(FREQ_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_valid (line_valid),
  .phase_err  (phase_err),
  .err_late   (err_late),
  .vcr_det_en (vcr_det_en),
  .gain_state (gain_state),
  .phase_adj  (phase_adj),
  .freq_word  (freq_word),
  .late_flag  (late_flag)
);

// File: tb/gain_pll_ctrl_test.sv
`timescale 1ns/1ps
module gain_pll_ctrl_test;
  localparam int EW = 12;
  localparam int FW = 10;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 line_valid;
  logic signed [EW-1:0] phase_err;
  logic                 err_late;
  logic                 vcr_det_en;
  logic [2:0]           gain_state;
  logic signed [EW-1:0] phase_adj;
  logic signed [FW-1:0] freq_word;
  logic                 late_flag;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  gain_pll_ctrl #(.ERR_W(EW), .FREQ_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .phase_err(phase_err),
    .err_late(err_late), .vcr_det_en(vcr_det_en), .gain_state(gain_state),
    .phase_adj(phase_adj), .freq_word(freq_word), .late_flag(late_flag)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=below 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; line_valid = 1'b0; phase_err = '0; err_late = 1'b0; vcr_det_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input int e, input bit l);
    @(negedge clk);
    line_valid = 1'b1;
    phase_err  = EW'(e);
    err_late   = l;
    @(negedge clk);
    line_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; line_valid = 1'b1; phase_err = 12'sd700; err_late = 1'b1; vcr_det_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 state in reset", int'(gain_state), 1);
    chk("R1 adj in reset", int'(phase_adj), 0);
    chk("R1 freq in reset", int'(freq_word), 0);
    chk("R1 flag in reset", int'(late_flag), 0);
    line_valid = 1'b0;
    do_reset();
    chk("R1 state after release", int'(gain_state), 1);
  endtask

  task automatic t_gain_normal();
    do_reset();
    send(200, 1'b1);
    chk("R3 adj state1 +200", int'(phase_adj), 6);
    chk("R4 freq +200", int'(freq_word), 0);
    chk("R11 flag lag", int'(late_flag), 1);
    send(-640, 1'b0);
    chk("R3 adj state1 -640", int'(phase_adj), -20);
    chk("R4 freq -640", int'(freq_word), -2);
    chk("R11 flag lead", int'(late_flag), 0);
  endtask

  task automatic t_small();
    do_reset();
    for (int i = 0; i < 3; i++) send(100, 1'b1);
    chk("R7 state before run ends", int'(gain_state), 1);
    send(100, 1'b1);
    chk("R7 state1 to 2", int'(gain_state), 2);
    chk("R3 adj used state1", int'(phase_adj), 3);
    for (int i = 0; i < 4; i++) send(100, 1'b1);
    chk("R7 state2 to 3", int'(gain_state), 3);
    chk("R3 adj used state2", int'(phase_adj), 12);
    for (int i = 0; i < 4; i++) send(100, 1'b1);
    chk("R7 state3 holds", int'(gain_state), 3);
    chk("R3 adj used state3", int'(phase_adj), 25);
    chk("R4 freq after modest run", int'(freq_word), 4);
  endtask

  task automatic t_alt();
    do_reset();
    for (int i = 0; i < 8; i++) send((i % 2 == 0) ? 100 : -100, (i % 2 == 0));
    chk("R9 alternating signs stay normal", int'(gain_state), 1);
    chk("R3 adj -100 state1", int'(phase_adj), -4);
    chk("R11 flag after alternation", int'(late_flag), 0);
  endtask

  task automatic t_big();
    do_reset();
    for (int i = 0; i < 3; i++) send(300, 1'b1);
    chk("R6 state before large run ends", int'(gain_state), 1);
    send(300, 1'b1);
    chk("R6 large run to state5", int'(gain_state), 5);
    send(300, 1'b1);
    chk("R3 adj state5", int'(phase_adj), 150);
    chk("R4 freq frozen in state5", int'(freq_word), 0);
    for (int i = 0; i < 3; i++) send(0, 1'b0);
    chk("R8 no step before quiet run ends", int'(gain_state), 5);
    send(0, 1'b0);
    chk("R8 R12 step 5 to 4", int'(gain_state), 4);
    send(64, 1'b1);
    chk("R3 adj state4", int'(phase_adj), 32);
    chk("R4 freq state4", int'(freq_word), 2);
    chk("R7 modest line keeps state4", int'(gain_state), 4);
    for (int i = 0; i < 4; i++) send(0, 1'b0);
    chk("R8 step 4 to 3", int'(gain_state), 3);
    for (int i = 0; i < 3; i++) send(0, 1'b0);
    chk("R8 fresh run needed after step", int'(gain_state), 3);
    send(0, 1'b0);
    chk("R8 step 3 to 2", int'(gain_state), 2);
    for (int i = 0; i < 4; i++) send(0, 1'b0);
    chk("R8 step 2 to 1", int'(gain_state), 1);
    for (int i = 0; i < 4; i++) send(0, 1'b0);
    chk("R8 floor at state1", int'(gain_state), 1);
    chk("R4 freq kept across state changes", int'(freq_word), 2);
  endtask

  task automatic t_vcr();
    do_reset();
    vcr_det_en = 1'b1;
    send(600, 1'b1);
    chk("R10 boost on step", int'(phase_adj), 300);
    chk("R10 freq not boosted", int'(freq_word), 1);
    send(500, 1'b1);
    chk("R10 no boost below limit", int'(phase_adj), 15);
    do_reset();
    vcr_det_en = 1'b0;
    send(600, 1'b1);
    chk("R10 disabled no boost", int'(phase_adj), 18);
    chk("R10 disabled freq", int'(freq_word), 1);
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 140; i++) begin
      send(-2048, 1'b0);
      send(1, 1'b1);
    end
    chk("R5 saturate low", int'(freq_word), -512);
    send(2047, 1'b1);
    chk("R5 leave low limit", int'(freq_word), -509);
    for (int i = 0; i < 350; i++) begin
      send(2047, 1'b1);
      send(0, 1'b0);
    end
    chk("R5 saturate high", int'(freq_word), 511);
    chk("R6 state stays normal in sat test", int'(gain_state), 1);
    send(-2048, 1'b0);
    chk("R5 leave high limit", int'(freq_word), 507);
  endtask

  task automatic t_idle();
    do_reset();
    send(400, 1'b1);
    phase_err  = -12'sd1500;
    err_late   = 1'b0;
    vcr_det_en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 adj held", int'(phase_adj), 12);
    chk("R2 flag held", int'(late_flag), 1);
    chk("R2 freq held", int'(freq_word), 0);
    chk("R2 state held", int'(gain_state), 1);
  endtask

  initial begin
    rst_n = 1'b0; line_valid = 1'b0; phase_err = '0; err_late = 1'b0; vcr_det_en = 1'b0;
    t_reset();
    t_gain_normal();
    t_small();
    t_alt();
    t_big();
    t_vcr();
    t_sat();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule